// File: doc/BRIEF.md
# PLL Reprogramming Control Sequencer

This block drives the control pins of a fractional-N PLL whenever software or a higher-level controller asks for a new divider setting. A request carries four values: a 10-bit feedback multiplier (m), a 6-bit input pre-divider (p), a 3-bit output shift (s) and a signed 16-bit fraction (k). The sequencer compares the requested m and p with the values now held. When they match, only s and k need to change, and this can be done without disturbing the loop. That light path finishes in a single cycle. When m or p differ, the sequencer runs a full relock. It holds the PLL in reset, routes the reference through bypass, loads every divider and waits a settle interval. It then releases reset, waits for lock within a bounded window and finally returns the output to the PLL.

The same engine also handles power-up and power-down requests. A power-up on a PLL that is already running completes at once. Otherwise it performs bypass, release, lock wait and bypass exit. A power-down simply holds the PLL in reset. The analog loop is outside the block; it is visible only through its lock indication. The settle interval and the lock timeout are both counted in clock cycles set by parameters. A parameter also selects a variant that switches the lock-detect source before the first reset assertion of a full relock.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, pll_rst_n is 0, pll_bypass, pll_lock_sel, busy, done and err_timeout are 0, and div_m, div_p, div_s and div_k are all zero.
- R2: A divider request whose m and p equal div_m and div_p updates only div_s and div_k, on the clock edge after the accepting edge. done pulses on that same edge, and pll_rst_n and pll_bypass do not move.
- R3: A divider request whose m or p differs runs a full relock, one control step per cycle, in this order. First pll_lock_sel is raised (only when LOCKSEL_EN is 1). Then pll_rst_n falls, then pll_bypass rises, then all four dividers are loaded. Dividers m and p never change while pll_rst_n is 1.
- R4: In a full relock, pll_rst_n rises no sooner than SETTLE_CYC cycles after the dividers are loaded.
- R5: After reset release, pll_bypass falls only after pll_lock has been seen high. done pulses for exactly one cycle on that same edge.
- R6: If pll_lock stays low for LOCK_TMO_CYC cycles after reset release, err_timeout becomes 1 and remains 1 while idle. busy falls with no done pulse, and pll_bypass stays 1.
- R7: err_timeout is cleared by the next accepted request.
- R8: A power-up request while pll_rst_n is already 1 completes with a done pulse on the edge after acceptance, and no control output changes.
- R9: A power-up request while pll_rst_n is 0 raises pll_bypass, then releases pll_rst_n, waits for lock, clears pll_bypass and pulses done.
- R10: A power-down request drives pll_rst_n to 0 and pulses done on the edge after acceptance.
- R11: busy is 1 from the accepting edge until done or err_timeout is reported. Any request that arrives while busy is 1 is dropped.
- R12: When requests arrive together, a divider request beats power-up, and power-up beats power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| prog_req | input | 1 | Divider change request, sampled while idle |
| prog_m | input | 10 | Requested feedback multiplier |
| prog_p | input | 6 | Requested pre-divider |
| prog_s | input | 3 | Requested output shift |
| prog_k | input | 16 | Requested signed fraction |
| pwr_up_req | input | 1 | Power-up request |
| pwr_dn_req | input | 1 | Power-down request |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_rst_n | output | 1 | Active-low PLL reset / power-down |
| pll_bypass | output | 1 | Route reference straight to the PLL output |
| pll_lock_sel | output | 1 | Lock-detect source select (variant) |
| div_m | output | 10 | Applied multiplier |
| div_p | output | 6 | Applied pre-divider |
| div_s | output | 3 | Applied output shift |
| div_k | output | 16 | Applied fraction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Sticky lock-timeout error |

## Verification
The divider path is tried with three kinds of request. One changes m from the reset value, and the full relock is expected. One keeps m and p but changes s and a negative k; this must finish in one cycle with no reset. The last is a full relock during which the lock never arrives, which separates a proper abort from a hang or a false done. Power-up is applied both with the PLL held in reset and with it already running, so the bench can tell the relock path from the immediate completion. The three request inputs are also asserted together, which shows the priority order, and extra requests are sent while a relock is in progress, which shows that they are dropped.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int M_W = 10;
    localparam int P_W = 6;
    localparam int S_W = 3;
    localparam int K_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_LIGHT  = 4'd1,
        ST_LSEL   = 4'd2,
        ST_RST    = 4'd3,
        ST_BYP    = 4'd4,
        ST_LOAD   = 4'd5,
        ST_SETTLE = 4'd6,
        ST_PUBYP  = 4'd7,
        ST_REL    = 4'd8,
        ST_WLOCK  = 4'd9,
        ST_EXIT   = 4'd10,
        ST_FIN    = 4'd11,
        ST_PDN    = 4'd12
    } seq_state_e;

    typedef struct packed {
        logic [M_W-1:0]        m;
        logic [P_W-1:0]        p;
        logic [S_W-1:0]        s;
        logic signed [K_W-1:0] k;
    } div_cfg_t;

    typedef struct packed {
        seq_state_e state;
        div_cfg_t   cur;
        div_cfg_t   nxt;
        logic       rstn;
        logic       bypass;
        logic       locksel;
        logic       busy;
        logic       done;
        logic       err;
    } seq_regs_t;

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
#(
    parameter bit LOCKSEL_EN   = 1'b1,
    parameter int SETTLE_CYC   = 150,
    parameter int LOCK_TMO_CYC = 500000,
    parameter int CNT_W        = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_req,
    input  div_cfg_t         prog_cfg,
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             pll_lock,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_regs_t        st_q
);

    seq_regs_t d, q;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.state)
            ST_IDLE: begin
                if (prog_req) begin
                    d.nxt  = prog_cfg;
                    d.err  = 1'b0;
                    d.busy = 1'b1;
                    if (prog_cfg.m == q.cur.m && prog_cfg.p == q.cur.p) begin
                        d.state = ST_LIGHT;
                    end else begin
                        d.state = LOCKSEL_EN ? ST_LSEL : ST_RST;
                    end
                end else if (up_req) begin
                    d.err   = 1'b0;
                    d.busy  = 1'b1;
                    d.state = q.rstn ? ST_FIN : ST_PUBYP;
                end else if (dn_req) begin
                    d.err   = 1'b0;
                    d.busy  = 1'b1;
                    d.state = ST_PDN;
                end
            end
            ST_LIGHT: begin
                d.cur.s = q.nxt.s;
                d.cur.k = q.nxt.k;
                d.done  = 1'b1;
                d.busy  = 1'b0;
                d.state = ST_IDLE;
            end
            ST_LSEL: begin
                d.locksel = 1'b1;
                d.state   = ST_RST;
            end
            ST_RST: begin
                d.rstn  = 1'b0;
                d.state = ST_BYP;
            end
            ST_BYP: begin
                d.bypass = 1'b1;
                d.state  = ST_LOAD;
            end
            ST_LOAD: begin
                d.cur    = q.nxt;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETTLE_CYC - 1);
                d.state  = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    d.state = ST_REL;
                end
            end
            ST_PUBYP: begin
                d.bypass = 1'b1;
                d.state  = ST_REL;
            end
            ST_REL: begin
                d.rstn   = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LOCK_TMO_CYC - 1);
                d.state  = ST_WLOCK;
            end
            ST_WLOCK: begin
                if (pll_lock) begin
                    d.state = ST_EXIT;
                end else if (tmr_zero) begin
                    d.err   = 1'b1;
                    d.busy  = 1'b0;
                    d.state = ST_IDLE;
                end
            end
            ST_EXIT: begin
                d.bypass = 1'b0;
                d.done   = 1'b1;
                d.busy   = 1'b0;
                d.state  = ST_IDLE;
            end
            ST_FIN: begin
                d.done  = 1'b1;
                d.busy  = 1'b0;
                d.state = ST_IDLE;
            end
            ST_PDN: begin
                d.rstn  = 1'b0;
                d.done  = 1'b1;
                d.busy  = 1'b0;
                d.state = ST_IDLE;
            end
            default: begin
                d.busy  = 1'b0;
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign st_q = q;

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pllseq_pkg::*;
#(
    parameter bit LOCKSEL_EN   = 1'b1,
    parameter int SETTLE_CYC   = 150,
    parameter int LOCK_TMO_CYC = 500000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_req,
    input  logic [M_W-1:0] prog_m,
    input  logic [P_W-1:0] prog_p,
    input  logic [S_W-1:0] prog_s,
    input  logic [K_W-1:0] prog_k,
    input  logic           pwr_up_req,
    input  logic           pwr_dn_req,
    input  logic           pll_lock,
    output logic           pll_rst_n,
    output logic           pll_bypass,
    output logic           pll_lock_sel,
    output logic [M_W-1:0] div_m,
    output logic [P_W-1:0] div_p,
    output logic [S_W-1:0] div_s,
    output logic [K_W-1:0] div_k,
    output logic           busy,
    output logic           done,
    output logic           err_timeout
);

    localparam int T_MAX = (SETTLE_CYC > LOCK_TMO_CYC) ? SETTLE_CYC : LOCK_TMO_CYC;
    localparam int CNT_W = $clog2(T_MAX + 1);

    div_cfg_t         req_cfg;
    seq_regs_t        st;
    logic             tmr_load;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    assign req_cfg.m = prog_m;
    assign req_cfg.p = prog_p;
    assign req_cfg.s = prog_s;
    assign req_cfg.k = prog_k;

    pllseq_ctrl #(
        .LOCKSEL_EN  (LOCKSEL_EN),
        .SETTLE_CYC  (SETTLE_CYC),
        .LOCK_TMO_CYC(LOCK_TMO_CYC),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_req(prog_req),
        .prog_cfg(req_cfg),
        .up_req  (pwr_up_req),
        .dn_req  (pwr_dn_req),
        .pll_lock(pll_lock),
        .tmr_zero(tmr_zero),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val),
        .st_q    (st)
    );

    pllseq_timer #(
        .W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    assign pll_rst_n    = st.rstn;
    assign pll_bypass   = st.bypass;
    assign pll_lock_sel = st.locksel;
    assign div_m        = st.cur.m;
    assign div_p        = st.cur.p;
    assign div_s        = st.cur.s;
    assign div_k        = st.cur.k;
    assign busy         = st.busy;
    assign done         = st.done;
    assign err_timeout  = st.err;

endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk
    import pllseq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           pll_lock,
    input logic           pll_rst_n,
    input logic           pll_bypass,
    input logic [M_W-1:0] div_m,
    input logic [P_W-1:0] div_p,
    input logic [S_W-1:0] div_s,
    input logic           busy,
    input logic           done,
    input logic           err_timeout
);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    byp_under_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_bypass) |-> !pll_rst_n);

    // R5
    byp_exit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_bypass) |-> (pll_rst_n && $past(pll_lock) && done));

    // R3
    mp_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(div_m) || !$stable(div_p)) |-> !pll_rst_n);

    // R2
    s_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_s) |-> (!pll_rst_n || done));

    // R6
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (!busy && !done && pll_bypass));

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_timeout) |-> busy);

endmodule

bind pll_reprog_seq pllseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_lock   (pll_lock),
    .pll_rst_n  (pll_rst_n),
    .pll_bypass (pll_bypass),
    .div_m      (div_m),
    .div_p      (div_p),
    .div_s      (div_s),
    .busy       (busy),
    .done       (done),
    .err_timeout(err_timeout)
);

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;

    localparam int SETTLE = 4;
    localparam int TMO    = 20;
    localparam int LDLY   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_req = 1'b0;
    logic [9:0]  prog_m = '0;
    logic [5:0]  prog_p = '0;
    logic [2:0]  prog_s = '0;
    logic [15:0] prog_k = '0;
    logic        pwr_up_req = 1'b0;
    logic        pwr_dn_req = 1'b0;
    logic        pll_lock = 1'b0;
    logic        pll_rst_n, pll_bypass, pll_lock_sel, busy, done, err_timeout;
    logic [9:0]  div_m;
    logic [5:0]  div_p;
    logic [2:0]  div_s;
    logic [15:0] div_k;

    int n_run  = 0;
    int n_fail = 0;
    bit lock_never = 1'b0;
    int lock_cnt = 0;

    int cyc = 0;
    int t_lsel, t_rfall, t_rrise, t_brise, t_bfall, t_load, t_done, t_err;
    logic p_lsel, p_rstn, p_byp, p_err;
    logic [9:0] p_m;
    logic [5:0] p_p;

    always #10 clk = ~clk;

    pll_reprog_seq #(
        .LOCKSEL_EN  (1'b1),
        .SETTLE_CYC  (SETTLE),
        .LOCK_TMO_CYC(TMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_m(prog_m),
        .prog_p(prog_p), .prog_s(prog_s), .prog_k(prog_k),
        .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req), .pll_lock(pll_lock),
        .pll_rst_n(pll_rst_n), .pll_bypass(pll_bypass), .pll_lock_sel(pll_lock_sel),
        .div_m(div_m), .div_p(div_p), .div_s(div_s), .div_k(div_k),
        .busy(busy), .done(done), .err_timeout(err_timeout)
    );

    // PLL model: lock some cycles after reset release
    always @(negedge clk) begin
        if (!pll_rst_n || lock_never) begin
            lock_cnt = 0;
            pll_lock = 1'b0;
        end else if (lock_cnt < LDLY) begin
            lock_cnt = lock_cnt + 1;
        end else begin
            pll_lock = 1'b1;
        end
    end

    // event tracker: first cycle of each output event
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pll_lock_sel && !p_lsel && t_lsel < 0) t_lsel = cyc;
        if (!pll_rst_n && p_rstn && t_rfall < 0) t_rfall = cyc;
        if (pll_rst_n && !p_rstn && t_rrise < 0) t_rrise = cyc;
        if (pll_bypass && !p_byp && t_brise < 0) t_brise = cyc;
        if (!pll_bypass && p_byp && t_bfall < 0) t_bfall = cyc;
        if ((div_m != p_m || div_p != p_p) && t_load < 0) t_load = cyc;
        if (done && t_done < 0) t_done = cyc;
        if (err_timeout && !p_err && t_err < 0) t_err = cyc;
        p_lsel = pll_lock_sel; p_rstn = pll_rst_n; p_byp = pll_bypass;
        p_err = err_timeout; p_m = div_m; p_p = div_p;
    end

    task automatic trk_clear();
        t_lsel = -1; t_rfall = -1; t_rrise = -1; t_brise = -1;
        t_bfall = -1; t_load = -1; t_done = -1; t_err = -1;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input bit pr, input bit up, input bit dn, input int m,
                        input int p, input int s, input int k);
        tick();
        trk_clear();
        prog_req = pr; pwr_up_req = up; pwr_dn_req = dn;
        prog_m = 10'(m); prog_p = 6'(p); prog_s = 3'(s); prog_k = 16'(k);
        tick();
        prog_req = 1'b0; pwr_up_req = 1'b0; pwr_dn_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (!busy) break;
            tick();
        end
    endtask

    task automatic t_reset();
        check(pll_rst_n == 0, "R1", "pll_rst_n", pll_rst_n, 0);
        check(pll_bypass == 0 && pll_lock_sel == 0, "R1", "bypass|locksel",
              {pll_bypass, pll_lock_sel}, 0);
        check(busy == 0 && done == 0 && err_timeout == 0, "R1", "busy|done|err",
              {busy, done, err_timeout}, 0);
        check(div_m == 0 && div_p == 0 && div_s == 0 && div_k == 0, "R1", "dividers",
              int'(div_m) + int'(div_p) + int'(div_s) + int'(div_k), 0);
    endtask

    task automatic t_pwrup_cold();
        send(0, 1, 0, 0, 0, 0, 0);
        check(busy == 1, "R11", "busy after accept", busy, 1);
        wait_idle();
        tick();
        check(t_brise > 0 && t_rrise > t_brise, "R9", "bypass before release",
              t_rrise - t_brise, 1);
        check(t_bfall > t_rrise && t_done == t_bfall, "R9", "bypass exit after lock",
              t_bfall, t_done);
        check(pll_rst_n == 1 && pll_bypass == 0, "R9", "final rstn|bypass",
              {pll_rst_n, pll_bypass}, 2);
    endtask

    task automatic t_pwrup_warm();
        send(0, 1, 0, 0, 0, 0, 0);
        tick();
        check(done == 1, "R8", "immediate done", done, 1);
        check(t_rfall < 0 && t_brise < 0 && pll_rst_n == 1, "R8", "no control change",
              t_rfall, -1);
    endtask

    task automatic t_full();
        send(1, 0, 0, 100, 3, 1, 5);
        wait_idle();
        tick();
        check(t_lsel > 0 && t_rfall == t_lsel + 1, "R3", "locksel then reset",
              t_rfall - t_lsel, 1);
        check(t_brise == t_rfall + 1 && t_load == t_brise + 1, "R3", "bypass then load",
              t_load - t_rfall, 2);
        check(t_rrise - t_load >= SETTLE, "R4", "settle cycles", t_rrise - t_load, SETTLE);
        check(t_bfall > t_rrise && t_done == t_bfall, "R5", "bypass exit with done",
              t_done, t_bfall);
        check(div_m == 100 && div_p == 3 && div_s == 1 && div_k == 5, "R3", "div_m",
              int'(div_m), 100);
        check(done == 0, "R5", "done one cycle", done, 0);
    endtask

    task automatic t_light();
        send(1, 0, 0, 100, 3, 4, -7);
        tick();
        check(done == 1 && div_s == 4, "R2", "div_s with done", int'(div_s), 4);
        check(div_k == 16'hFFF9, "R2", "div_k", int'(div_k), 'hFFF9);
        check(t_rfall < 0 && t_brise < 0 && div_m == 100, "R2", "no reset/bypass",
              t_rfall, -1);
    endtask

    task automatic t_busy_drop();
        send(1, 0, 0, 200, 3, 0, 0);
        tick();
        prog_req = 1'b1; prog_m = 10'd300; pwr_dn_req = 1'b1;
        tick();
        prog_req = 1'b0; pwr_dn_req = 1'b0;
        wait_idle();
        tick();
        check(div_m == 200, "R11", "request dropped while busy", int'(div_m), 200);
        check(pll_rst_n == 1, "R11", "power-down dropped", pll_rst_n, 1);
    endtask

    task automatic t_timeout();
        lock_never = 1'b1;
        send(1, 0, 0, 50, 2, 0, 0);
        wait_idle();
        tick();
        check(err_timeout == 1 && busy == 0, "R6", "err raised", err_timeout, 1);
        check(t_done < 0 && pll_bypass == 1, "R6", "no done, bypass held", t_done, -1);
        check(t_err - t_rrise >= TMO, "R6", "timeout window", t_err - t_rrise, TMO);
        for (int i = 0; i < 5; i++) tick();
        check(err_timeout == 1, "R6", "err sticky", err_timeout, 1);
        lock_never = 1'b0;
        send(1, 0, 0, 60, 2, 0, 0);
        check(err_timeout == 0, "R7", "err cleared on accept", err_timeout, 1'b0);
        wait_idle();
        tick();
        check(t_done > 0 && pll_bypass == 0 && div_m == 60, "R7", "recovered relock",
              int'(div_m), 60);
    endtask

    task automatic t_priority();
        send(1, 1, 1, 60, 2, 6, 0);
        tick();
        check(done == 1 && div_s == 6 && pll_rst_n == 1, "R12", "divider request wins",
              int'(div_s), 6);
    endtask

    task automatic t_pwrdn();
        send(0, 0, 1, 0, 0, 0, 0);
        tick();
        check(pll_rst_n == 0 && done == 1, "R10", "power-down", pll_rst_n, 0);
    endtask

    initial begin
        #2000000;
        n_fail = n_fail + 1;
        n_run = n_run + 1;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        trk_clear();
        p_lsel = 0; p_rstn = 0; p_byp = 0; p_err = 0; p_m = '0; p_p = '0;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_pwrup_cold();
        t_pwrup_warm();
        t_full();
        t_light();
        t_busy_drop();
        t_timeout();
        t_priority();
        t_pwrdn();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule